// File: doc/BRIEF.md
# Alphanumeric Display Segment Latch

The block gathers segment patterns for two rows of 14-segment display digits from byte-wide register writes by a host processor. A position register picks the digit that later writes touch. Four data offsets each OR a byte into the low or high half of a 16-bit entry, in either row. Writes only set bits, so software can build a character over several writes. Bits are cleared only when the frame completes.

A frame tick copies the shown entries into a snapshot and clears the whole store in the same cycle. While copying, it reorders each entry's bits into the wire order the display driver expects. The snapshot is then sent out as a stream of 32 digit words under valid/ready flow control. Digits 0 to 15 come from the first row and digits 16 to 31 from the second row. The snapshot keeps the last frame until the next tick. When the sink stalls, the current word is held unchanged. A new tick abandons any stream still in progress and starts again at digit 0 with the new frame.

Top module: `alnum_seg_latch`

## Requirements
- R1: A write to offset 0x3B loads the digit position from data bits 4:0. Data bits 7:5 are ignored.
- R2: A write to 0x3C ORs the data into bits 7:0 of row-1 entry `position`, and a write to 0x3D ORs it into bits 15:8. Stored bits are never cleared by a write.
- R3: Writes to 0x3E and 0x3F do the same for row 2, using entry `position + 20` of the 40-entry store.
- R4: A row write whose entry index would exceed 39 changes nothing. A write to any offset other than 0x3B to 0x3F changes nothing.
- R5: Each frame tick outputs 32 digits. Digit d (0 to 15) shows entry d, and digit 16+d shows entry 20+d.
- R6: Output bits 15 down to 0 are stored bits 7, 15, 12, 10, 8, 14, 13, 9, 11, 6, 5, 4, 3, 2, 1, 0, in that order.
- R7: A tick clears all 40 entries after they are captured. A write in the same cycle as a tick lands in the cleared store and does not appear in the frame being captured.
- R8: `seg_valid` rises in the cycle after a tick with `seg_digit` equal to 0. Digit and pattern stay stable while valid is high and ready is low. The digit index advances by one on each handshake. Valid falls after digit 31 is accepted. A tick restarts the stream at digit 0.
- R9: After reset, `seg_valid` is low, all entries are zero and the position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register offset |
| wr_data | input | 8 | Write data byte |
| frame_tick | input | 1 | One-cycle frame pulse: capture, clear, start stream |
| seg_valid | output | 1 | Stream word valid |
| seg_ready | input | 1 | Sink accepts the word |
| seg_digit | output | 5 | Digit index 0 to 31 |
| seg_pattern | output | 16 | Reordered segment pattern |

## Verification
The assertions check these rules on every cycle:
- stored bits only accumulate between ticks;
- the store is empty after a tick that has no write with it;
- an out-of-range row-2 write leaves the store untouched;
- the stream restarts at digit 0, holds its word while stalled, steps by one per handshake and ends after the last digit.

Only the bench's scenarios can show the rest:
- the exact bit reordering and the mapping of entries to digits;
- that row-1 position 25 appears as second-row digit 5;
- that a write made with a tick reaches the next frame and not the current one;
- that a tick in mid-stream delivers the new frame.

// File: rtl/alnum_pkg.sv
package alnum_pkg;
  // Register offsets: the host software decodes these, so they stay fixed.
  localparam logic [7:0] OFS_POS   = 8'h3B;
  localparam logic [7:0] OFS_R1_LO = 8'h3C;
  localparam logic [7:0] OFS_R1_HI = 8'h3D;
  localparam logic [7:0] OFS_R2_LO = 8'h3E;
  localparam logic [7:0] OFS_R2_HI = 8'h3F;

  localparam int SEG_W = 16;

  // Reorder stored segment bits into the driver's wire order.
  function automatic logic [15:0] seg_permute(input logic [15:0] s);
    return {s[7], s[15], s[12], s[10], s[8], s[14], s[13], s[9], s[11], s[6:0]};
  endfunction
endpackage

// File: rtl/alnum_store.sv
module alnum_store #(
  parameter int ENTRIES = 40,
  parameter int ROW_OFS = 20,
  parameter int POS_W   = 5,
  parameter int ADDR_W  = 8,
  parameter int SEG_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [SEG_W/2-1:0]       wr_data,
  input  logic                     clear,
  output logic [ENTRIES*SEG_W-1:0] store_flat
);
  localparam int HALF = SEG_W / 2;
  localparam int IW   = $clog2(ENTRIES + (1 << POS_W)) + 1;

  logic [POS_W-1:0] pos_q;
  logic [IW-1:0]    r1_idx, r2_idx;
  logic             r1_ok, r2_ok;
  logic             sel_pos, sel_r1lo, sel_r1hi, sel_r2lo, sel_r2hi;

  assign sel_pos  = wr_en && (wr_addr == ADDR_W'(alnum_pkg::OFS_POS));
  assign sel_r1lo = wr_en && (wr_addr == ADDR_W'(alnum_pkg::OFS_R1_LO));
  assign sel_r1hi = wr_en && (wr_addr == ADDR_W'(alnum_pkg::OFS_R1_HI));
  assign sel_r2lo = wr_en && (wr_addr == ADDR_W'(alnum_pkg::OFS_R2_LO));
  assign sel_r2hi = wr_en && (wr_addr == ADDR_W'(alnum_pkg::OFS_R2_HI));

  assign r1_idx = IW'(pos_q);
  assign r2_idx = IW'(pos_q) + IW'(ROW_OFS);
  assign r1_ok  = r1_idx < IW'(ENTRIES);
  assign r2_ok  = r2_idx < IW'(ENTRIES);

  always_ff @(posedge clk) begin
    if (!rst_n)       pos_q <= '0;
    else if (sel_pos) pos_q <= wr_data[POS_W-1:0];
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [SEG_W-1:0] ent_q, ent_d;
    logic             hit_lo, hit_hi;

    always_comb begin
      hit_lo = (sel_r1lo && r1_ok && r1_idx == IW'(e)) ||
               (sel_r2lo && r2_ok && r2_idx == IW'(e));
      hit_hi = (sel_r1hi && r1_ok && r1_idx == IW'(e)) ||
               (sel_r2hi && r2_ok && r2_idx == IW'(e));
      // Clear first, then merge any same-cycle write.
      ent_d  = (clear ? '0 : ent_q) |
               {(hit_hi ? wr_data : HALF'(0)), (hit_lo ? wr_data : HALF'(0))};
    end

    always_ff @(posedge clk) begin
      if (!rst_n) ent_q <= '0;
      else        ent_q <= ent_d;
    end

    assign store_flat[e*SEG_W +: SEG_W] = ent_q;
  end

  AST_BITS_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((store_flat & $past(store_flat)) == $past(store_flat))); // R2
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !wr_en) |=> (store_flat == '0)); // R7
  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_r2lo || sel_r2hi) && !r2_ok && !clear) |=> $stable(store_flat)); // R4
endmodule

// File: rtl/alnum_frame.sv
module alnum_frame #(
  parameter int ENTRIES    = 40,
  parameter int ROW_OFS    = 20,
  parameter int ROW_DIGITS = 16,
  parameter int SEG_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          capture,
  input  logic [ENTRIES*SEG_W-1:0]      store_flat,
  output logic [2*ROW_DIGITS*SEG_W-1:0] frame_flat
);
  localparam int DIGITS = 2 * ROW_DIGITS;

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    localparam int SRC = (d < ROW_DIGITS) ? d : (d - ROW_DIGITS + ROW_OFS);
    logic [SEG_W-1:0] snap_q;

    always_ff @(posedge clk) begin
      if (!rst_n)       snap_q <= '0;
      else if (capture) snap_q <= alnum_pkg::seg_permute(store_flat[SRC*SEG_W +: SEG_W]);
    end

    assign frame_flat[d*SEG_W +: SEG_W] = snap_q;
  end
endmodule

// File: rtl/alnum_stream.sv
module alnum_stream #(
  parameter int DIGITS = 32,
  parameter int SEG_W  = 16,
  parameter int DW     = $clog2(DIGITS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DIGITS*SEG_W-1:0] frame_flat,
  input  logic                    seg_ready,
  output logic                    seg_valid,
  output logic [DW-1:0]           seg_digit,
  output logic [SEG_W-1:0]        seg_pattern
);
  localparam logic [DW-1:0] LAST = DW'(DIGITS - 1);

  logic [DW-1:0] cnt_q;
  logic          valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (valid_q && seg_ready) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        valid_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign seg_valid   = valid_q;
  assign seg_digit   = cnt_q;
  assign seg_pattern = frame_flat[int'(cnt_q)*SEG_W +: SEG_W];

  AST_START_DIGIT0: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (seg_valid && seg_digit == '0)); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready && !start) |=>
      (seg_valid && $stable(seg_digit) && $stable(seg_pattern))); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready && !start && seg_digit != LAST) |=>
      (seg_valid && seg_digit == $past(seg_digit) + 1'b1)); // R8
  AST_LAST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && seg_ready && !start && seg_digit == LAST) |=> !seg_valid); // R8
endmodule

// File: rtl/alnum_seg_latch.sv
module alnum_seg_latch #(
  parameter int ENTRIES    = 40,
  parameter int ROW_OFS    = 20,
  parameter int ROW_DIGITS = 16,
  parameter int POS_W      = 5,
  parameter int ADDR_W     = 8,
  parameter int SEG_W      = alnum_pkg::SEG_W,
  parameter int DIGITS     = 2 * ROW_DIGITS,
  parameter int DW         = $clog2(DIGITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [SEG_W/2-1:0] wr_data,
  input  logic               frame_tick,
  output logic               seg_valid,
  input  logic               seg_ready,
  output logic [DW-1:0]      seg_digit,
  output logic [SEG_W-1:0]   seg_pattern
);
  logic [ENTRIES*SEG_W-1:0] store_flat;
  logic [DIGITS*SEG_W-1:0]  frame_flat;

  alnum_store #(.ENTRIES(ENTRIES), .ROW_OFS(ROW_OFS), .POS_W(POS_W),
                .ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .clear(frame_tick), .store_flat(store_flat));

  alnum_frame #(.ENTRIES(ENTRIES), .ROW_OFS(ROW_OFS),
                .ROW_DIGITS(ROW_DIGITS), .SEG_W(SEG_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .capture(frame_tick),
    .store_flat(store_flat), .frame_flat(frame_flat));

  alnum_stream #(.DIGITS(DIGITS), .SEG_W(SEG_W), .DW(DW)) u_stream (
    .clk(clk), .rst_n(rst_n), .start(frame_tick), .frame_flat(frame_flat),
    .seg_ready(seg_ready), .seg_valid(seg_valid), .seg_digit(seg_digit),
    .seg_pattern(seg_pattern));
endmodule

// File: tb/alnum_seg_latch_tb_top.sv
module alnum_seg_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        frame_tick = 1'b0;
  logic        seg_ready = 1'b0;
  logic        seg_valid;
  logic [4:0]  seg_digit;
  logic [15:0] seg_pattern;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] mdl [40];
  logic [15:0] expf [32];
  int          mpos;

  always #5 clk = ~clk;

  alnum_seg_latch dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_tick(frame_tick), .seg_valid(seg_valid),
    .seg_ready(seg_ready), .seg_digit(seg_digit), .seg_pattern(seg_pattern));

  // Stimulus table: {offset, data}
  localparam logic [15:0] VEC [14] = '{
    {8'h3B, 8'h00}, {8'h3C, 8'h81}, {8'h3D, 8'h40}, {8'h3C, 8'h02},
    {8'h3B, 8'hE7}, {8'h3E, 8'h55}, {8'h3F, 8'hAA}, {8'h3B, 8'h0F},
    {8'h3D, 8'hFF}, {8'h3F, 8'h01}, {8'h3B, 8'h19}, {8'h3C, 8'h33},
    {8'h3E, 8'h77}, {8'h3A, 8'hFF}};

  // R6: out[15..0] = in[7,15,12,10,8,14,13,9,11,6,5,4,3,2,1,0]
  function automatic logic [15:0] ref_perm(input logic [15:0] s);
    logic [15:0] o;
    o[15] = s[7];  o[14] = s[15]; o[13] = s[12]; o[12] = s[10];
    o[11] = s[8];  o[10] = s[14]; o[9]  = s[13]; o[8]  = s[9];
    o[7]  = s[11];
    for (int b = 0; b < 7; b++) o[b] = s[b];
    return o;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h3B: mpos = int'(d[4:0]);
      8'h3C: if (mpos < 40) mdl[mpos][7:0]  = mdl[mpos][7:0]  | d;
      8'h3D: if (mpos < 40) mdl[mpos][15:8] = mdl[mpos][15:8] | d;
      8'h3E: if (mpos + 20 < 40) mdl[mpos+20][7:0]  = mdl[mpos+20][7:0]  | d;
      8'h3F: if (mpos + 20 < 40) mdl[mpos+20][15:8] = mdl[mpos+20][15:8] | d;
      default: ;
    endcase
  endtask

  task automatic model_tick();
    for (int d = 0; d < 16; d++) begin
      expf[d]      = ref_perm(mdl[d]);
      expf[d + 16] = ref_perm(mdl[d + 20]);
    end
    for (int e = 0; e < 40; e++) mdl[e] = '0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_tick();
    frame_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    frame_tick = 1'b0;
    model_tick();
  endtask

  // Tick with a write in the same cycle (R7)
  task automatic do_tick_write(input logic [7:0] a, input logic [7:0] d);
    frame_tick = 1'b1; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    frame_tick = 1'b0; wr_en = 1'b0;
    model_tick();
    model_write(a, d);
  endtask

  task automatic drain(input string tag, input int from);
    seg_ready = 1'b1;
    for (int i = from; i < 32; i++) begin
      check({tag, " R8 valid"}, 32'(seg_valid), 32'd1);
      check({tag, " R8 digit"}, 32'(seg_digit), 32'(i));
      check({tag, " R5 R6 pattern"}, 32'(seg_pattern), 32'(expf[i]));
      @(negedge clk);
    end
    seg_ready = 1'b0;
    check({tag, " R8 valid drops"}, 32'(seg_valid), 32'd0);
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < 40; e++) mdl[e] = '0;
    mpos = 0;
    repeat (3) @(negedge clk);
    check("R9 valid low in reset", 32'(seg_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 valid low after reset", 32'(seg_valid), 32'd0);

    // R9: store zero and position 0 after reset
    do_write(8'h3C, 8'h11);
    do_tick();
    drain("R9 reset frame", 0);

    // Table walk: R1 R2 R3 R4 R5 R6
    foreach (VEC[k]) do_write(VEC[k][15:8], VEC[k][7:0]);
    do_tick();
    check("R4 row1 pos25 shows as digit 21", 32'(expf[21]), 32'(ref_perm(16'h0033)));
    drain("R1-table", 0);

    // R7: store cleared after a frame
    do_tick();
    drain("R7 cleared", 0);

    // R7: write together with a tick lands in the next frame
    do_write(8'h3B, 8'h03);
    do_write(8'h3C, 8'h0F);
    do_tick_write(8'h3D, 8'hF0);
    check("R7 captured frame excludes same-cycle write", 32'(expf[3]), 32'(ref_perm(16'h000F)));
    drain("R7 tick+write a", 0);
    do_tick();
    check("R7 next frame has write", 32'(expf[3]), 32'(ref_perm(16'hF000)));
    drain("R7 tick+write b", 0);

    // R8: back-pressure holds the word
    do_write(8'h3B, 8'h00);
    do_write(8'h3D, 8'h81);
    do_tick();
    repeat (3) @(negedge clk);
    check("R8 stall digit", 32'(seg_digit), 32'd0);
    check("R8 stall pattern", 32'(seg_pattern), 32'(expf[0]));
    drain("R8 stalled", 0);

    // R8: tick mid-stream restarts at digit 0 with the new frame
    do_write(8'h3C, 8'h44);
    do_tick();
    seg_ready = 1'b1;
    repeat (5) @(negedge clk);
    seg_ready = 1'b0;
    check("R8 mid-stream digit", 32'(seg_digit), 32'd5);
    do_write(8'h3C, 8'h08);
    do_tick();
    check("R8 restart digit", 32'(seg_digit), 32'd0);
    check("R8 restart pattern", 32'(seg_pattern), 32'(ref_perm(16'h0008)));
    drain("R8 restart", 0);

    // R4: unused offset and out-of-range row-2 write leave store unchanged
    do_write(8'h3B, 8'h14);
    do_write(8'h3F, 8'hFF);
    do_write(8'h40, 8'hFF);
    do_tick();
    drain("R4 ignored", 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule